// File: doc/BRIEF.md
# Near-Zero Activation Skip Filter

This block sits between a stream of signed 16-bit activations and a compute engine. It removes activations whose magnitude is too small to matter. The cut-off is a power-of-two threshold, programmed as an exponent that software may change between layers.

The test uses no magnitude comparator. A negative value is first bit-inverted. The result is shifted right by the exponent, and an all-zero result marks the item as near zero. Each activation arrives with its channel index and the address of its paired weight fetch. When an activation is dropped, its weight fetch is dropped too, so the engine never sees the pair.

Survivors leave in arrival order through one registered output slot that respects downstream back-pressure. A weight-fetch pulse with its address is issued in the same cycle that each survivor is handed over. Two 32-bit counters track items accepted and items skipped. A synchronous clear resets both.

Top module: `nz_skip_filter`

## Requirements
- R1: With exponent N (port `thr_exp`, unsigned) non-zero, a non-negative activation `a` is dropped exactly when `a >> N` is zero, that is when `a < 2**N`; otherwise it is forwarded.
- R2: A negative activation is dropped exactly when its bitwise inverse shifted right by N is zero, that is when `a >= -(2**N)`; with N=2 the values -4 through 3 are dropped, while -5 and 4 are forwarded.
- R3: N=0 disables skipping: every accepted activation, including zero, is forwarded.
- R4: The exponent is sampled in the cycle each activation is accepted, so a new value applies from the next accepted item on; with N=15 every 16-bit value, including -32768 and 32767, is dropped.
- R5: Forwarded activations appear on `out_act` in arrival order, each with its own `out_chan` and `out_waddr`. `wf_valid` pulses with `wf_addr` equal to the forwarded item's weight address exactly when `out_valid` and `out_ready` are both high; dropped items produce no pulse.
- R6: `total_cnt` increments by one for each accepted input beat (`in_valid` and `in_ready` high at a clock edge), and `skip_cnt` increments by one for each accepted beat that is dropped.
- R7: `clr` high at a clock edge zeroes both counters and takes priority over any increment in that cycle; it does not affect the data path.
- R8: While `out_valid` is high and `out_ready` is low, the output beat holds stable and `in_ready` is low; no item is lost or repeated across any stall pattern.
- R9: After reset `out_valid` and `wf_valid` are low, `in_ready` is high, and both counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous counter clear |
| thr_exp | input | 4 | Threshold exponent N (threshold = 2**N, 0 = off) |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat may be taken |
| in_act | input | 16 | Signed activation |
| in_chan | input | 8 | Channel index of the activation |
| in_waddr | input | 12 | Weight address paired with the activation |
| out_valid | output | 1 | Surviving beat valid |
| out_ready | input | 1 | Downstream can take the beat |
| out_act | output | 16 | Surviving activation |
| out_chan | output | 8 | Channel index of the survivor |
| out_waddr | output | 12 | Weight address of the survivor |
| wf_valid | output | 1 | Weight-fetch issue pulse |
| wf_addr | output | 12 | Address of the issued weight fetch |
| skip_cnt | output | 32 | Number of dropped activations |
| total_cnt | output | 32 | Number of accepted activations |

## Verification
The bench probes the exact edges of the band around zero: -5, -4, 3 and 4 at N=2, plus the two extreme 16-bit values at N=15. An off-by-one in the shift, or an arithmetic instead of logical treatment of the sign, would forward -4 or drop -5. It checks that N=0 lets zero through, which a design that forgot the disable would drop. It changes N between consecutive items, which would catch a design that latched the exponent late. It applies a pseudo-random ready pattern and a long explicit stall, under which a slot that overwrote or re-sent a beat would break the ordered survivor list or its weight pulses. It also raises the clear in the same cycle as an accepted beat, where a design that gave the increment priority would read one instead of zero.

// File: rtl/nzs_pkg.sv
package nzs_pkg;
    localparam int ACT_W = 16;
    localparam int EXP_W = $clog2(ACT_W);
    localparam int CH_W  = 8;
    localparam int WA_W  = 12;
    localparam int CNT_W = 32;

    typedef struct packed {
        logic [ACT_W-1:0] act;
        logic [CH_W-1:0]  chan;
        logic [WA_W-1:0]  waddr;
    } beat_t;
endpackage

// File: rtl/nzs_detect.sv
module nzs_detect
    import nzs_pkg::*;
(
    input  logic [ACT_W-1:0] act,
    input  logic [EXP_W-1:0] exp_n,
    output logic             near_zero
);
    logic [ACT_W-1:0] mag;
    logic [ACT_W-1:0] shifted;

    always_comb begin
        // sign-folded magnitude: negative values are bit-inverted
        mag       = act[ACT_W-1] ? ~act : act;
        shifted   = mag >> exp_n;
        near_zero = (exp_n != '0) && (shifted == '0);
    end
endmodule

// File: rtl/nzs_stage.sv
module nzs_stage
    import nzs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    output logic  in_ready,
    input  logic  keep,
    input  beat_t in_beat,
    output logic  out_valid,
    input  logic  out_ready,
    output beat_t out_beat
);
    typedef struct packed {
        logic  valid;
        beat_t beat;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        in_ready = !slot_q.valid || out_ready;
        slot_d   = slot_q;
        if (out_ready) begin
            slot_d.valid = 1'b0;
        end
        if (in_valid && in_ready && keep) begin
            slot_d.valid = 1'b1;
            slot_d.beat  = in_beat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign out_valid = slot_q.valid;
    assign out_beat  = slot_q.beat;

    assert_hold_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_beat)))
        else $error("stalled beat changed");

    assert_no_accept_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready)
        else $error("input taken while slot full and stalled");
endmodule

// File: rtl/nzs_counters.sv
module nzs_counters
    import nzs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             fire,
    input  logic             dropped,
    output logic [CNT_W-1:0] skip_cnt,
    output logic [CNT_W-1:0] total_cnt
);
    typedef struct packed {
        logic [CNT_W-1:0] skip;
        logic [CNT_W-1:0] total;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (fire) begin
            cnt_d.total = cnt_q.total + 1'b1;
            if (dropped) begin
                cnt_d.skip = cnt_q.skip + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign skip_cnt  = cnt_q.skip;
    assign total_cnt = cnt_q.total;

    assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (skip_cnt == '0 && total_cnt == '0))
        else $error("clear did not zero counters");

    assert_idle_no_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && !clr) |=> ($stable(total_cnt) && $stable(skip_cnt)))
        else $error("counter moved without an accepted beat");
endmodule

// File: rtl/nz_skip_filter.sv
module nz_skip_filter
    import nzs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [EXP_W-1:0] thr_exp,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [ACT_W-1:0] in_act,
    input  logic [CH_W-1:0]  in_chan,
    input  logic [WA_W-1:0]  in_waddr,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [ACT_W-1:0] out_act,
    output logic [CH_W-1:0]  out_chan,
    output logic [WA_W-1:0]  out_waddr,
    output logic             wf_valid,
    output logic [WA_W-1:0]  wf_addr,
    output logic [CNT_W-1:0] skip_cnt,
    output logic [CNT_W-1:0] total_cnt
);
    logic  near_zero;
    logic  in_fire;
    beat_t in_beat;
    beat_t out_beat;

    assign in_beat = '{act: in_act, chan: in_chan, waddr: in_waddr};

    nzs_detect u_detect (
        .act       (in_act),
        .exp_n     (thr_exp),
        .near_zero (near_zero)
    );

    nzs_stage u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .keep      (!near_zero),
        .in_beat   (in_beat),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_beat  (out_beat)
    );

    assign in_fire = in_valid && in_ready;

    nzs_counters u_counters (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .fire      (in_fire),
        .dropped   (near_zero),
        .skip_cnt  (skip_cnt),
        .total_cnt (total_cnt)
    );

    assign out_act   = out_beat.act;
    assign out_chan  = out_beat.chan;
    assign out_waddr = out_beat.waddr;
    assign wf_valid  = out_valid && out_ready;
    assign wf_addr   = out_beat.waddr;

    assert_zero_dropped_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fire && in_act == '0 && thr_exp != '0 && out_ready) |=> !out_valid)
        else $error("zero activation forwarded with skipping on");

    assert_off_forwards_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fire && thr_exp == '0) |=> (out_valid && out_act == $past(in_act)))
        else $error("item lost with skipping disabled");

    assert_max_exp_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fire && thr_exp == '1 && out_ready) |=> !out_valid)
        else $error("item forwarded at largest exponent");
endmodule

// File: tb/nz_skip_filter_bench.sv
`timescale 1ns/1ps
module nz_skip_filter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic [3:0]  thr_exp = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_act = '0;
    logic [7:0]  in_chan = '0;
    logic [11:0] in_waddr = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_act;
    logic [7:0]  out_chan;
    logic [11:0] out_waddr;
    logic        wf_valid;
    logic [11:0] wf_addr;
    logic [31:0] skip_cnt;
    logic [31:0] total_cnt;

    nz_skip_filter u_nz_skip_filter (
        .clk(clk), .rst_n(rst_n), .clr(clr), .thr_exp(thr_exp),
        .in_valid(in_valid), .in_ready(in_ready), .in_act(in_act),
        .in_chan(in_chan), .in_waddr(in_waddr),
        .out_valid(out_valid), .out_ready(out_ready), .out_act(out_act),
        .out_chan(out_chan), .out_waddr(out_waddr),
        .wf_valid(wf_valid), .wf_addr(wf_addr),
        .skip_cnt(skip_cnt), .total_cnt(total_cnt)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int exp_total = 0;
    int exp_skip = 0;
    int exp_n = 0;
    int got_n = 0;
    int wf_bad = 0;
    logic [15:0] exp_act [0:255];
    logic [7:0]  exp_chan[0:255];
    logic [11:0] exp_addr[0:255];
    logic [15:0] got_act [0:255];
    logic [7:0]  got_chan[0:255];
    logic [11:0] got_addr[0:255];
    logic [11:0] got_wf  [0:255];
    logic        stall_mode = 1'b0;
    logic [7:0]  lfsr = 8'hA5;

    always @(posedge clk) begin
        if (rst_n) begin
            if (wf_valid != (out_valid && out_ready)) wf_bad++;
            if (out_valid && out_ready && got_n < 256) begin
                got_act[got_n]  = out_act;
                got_chan[got_n] = out_chan;
                got_addr[got_n] = out_waddr;
                got_wf[got_n]   = wf_valid ? wf_addr : 12'hFFF;
                got_n++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic bit ref_drop(input logic signed [15:0] a, input int n);
        int v;
        v = a;
        return (n != 0) && (v >= -(1 << n)) && (v < (1 << n));
    endfunction

    task automatic pick_ready();
        if (stall_mode) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            out_ready = lfsr[0];
        end else begin
            out_ready = 1'b1;
        end
    endtask

    task automatic send(input logic signed [15:0] a, input int n,
                        input logic [7:0] ch, input logic [11:0] ad);
        @(negedge clk);
        thr_exp = n[3:0]; in_act = a; in_chan = ch; in_waddr = ad; in_valid = 1'b1;
        pick_ready();
        #1;
        while (!in_ready) begin
            @(negedge clk);
            pick_ready();
            #1;
        end
        exp_total++;
        if (ref_drop(a, n)) begin
            exp_skip++;
        end else begin
            exp_act[exp_n] = a; exp_chan[exp_n] = ch; exp_addr[exp_n] = ad;
            exp_n++;
        end
    endtask

    task automatic drain();
        @(negedge clk);
        in_valid = 1'b0;
        stall_mode = 1'b0;
        out_ready = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_stream(input int base, input string req);
        chk(got_n == exp_n, {req, " survivor count"}, got_n, exp_n);
        for (int i = base; i < exp_n && i < got_n; i++) begin
            chk(got_act[i] == exp_act[i], {req, " order/value"}, int'(got_act[i]), int'(exp_act[i]));
            chk(got_chan[i] == exp_chan[i], {req, " channel R5"}, got_chan[i], exp_chan[i]);
            chk(got_addr[i] == exp_addr[i] && got_wf[i] == exp_addr[i],
                {req, " weight fetch R5"}, got_wf[i], exp_addr[i]);
        end
        chk(wf_bad == 0, {req, " wf pulse R5"}, wf_bad, 0);
    endtask

    task automatic check_counts(input string req);
        chk(total_cnt == exp_total, {req, " total R6"}, total_cnt, exp_total);
        chk(skip_cnt == exp_skip, {req, " skip R6"}, skip_cnt, exp_skip);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!out_valid && !wf_valid, "R9 out_valid", out_valid, 0);
        chk(in_ready, "R9 in_ready", in_ready, 1);
        chk(skip_cnt == 0 && total_cnt == 0, "R9 counters", total_cnt, 0);
    endtask

    task automatic t_boundary_n2();
        int base = exp_n;
        logic signed [15:0] vals [0:10] = '{-16'sd6, -16'sd5, -16'sd4, -16'sd1, 16'sd0,
            16'sd1, 16'sd3, 16'sd4, 16'sd5, 16'sh7FFF, -16'sh8000};
        for (int i = 0; i < 11; i++) send(vals[i], 2, 8'(i + 10), 12'(i + 100));
        drain();
        check_stream(base, "R1 R2 N=2 band");
        chk(exp_n - base == 6, "R2 survivors at N=2", got_n - base, 6);
        check_counts("R6 after N=2");
    endtask

    task automatic t_disabled();
        int base = exp_n;
        send(16'sd0, 0, 8'd1, 12'd7);
        send(-16'sd1, 0, 8'd2, 12'd8);
        send(16'sd1, 0, 8'd3, 12'd9);
        drain();
        chk(got_n - base == 3, "R3 all forwarded", got_n - base, 3);
        check_stream(base, "R3 N=0");
    endtask

    task automatic t_max_exp();
        int base = exp_n;
        send(16'sh7FFF, 15, 8'd4, 12'd1);
        send(-16'sh8000, 15, 8'd5, 12'd2);
        send(16'sd1000, 15, 8'd6, 12'd3);
        send(-16'sd1000, 15, 8'd7, 12'd4);
        drain();
        chk(got_n == base, "R4 N=15 drops all", got_n - base, 0);
        check_counts("R4 N=15");
    endtask

    task automatic t_layer_change();
        int base = exp_n;
        send(16'sd7, 3, 8'd20, 12'd200);
        send(16'sd7, 1, 8'd21, 12'd201);
        send(-16'sd16, 4, 8'd22, 12'd202);
        send(-16'sd17, 4, 8'd23, 12'd203);
        send(16'sd2, 1, 8'd24, 12'd204);
        drain();
        chk(got_n - base == 3, "R4 per-item exponent", got_n - base, 3);
        check_stream(base, "R4 layer change");
    endtask

    task automatic t_hold();
        int base = exp_n;
        @(negedge clk);
        out_ready = 1'b0; thr_exp = 4'd2;
        in_act = 16'd500; in_chan = 8'd30; in_waddr = 12'd300; in_valid = 1'b1;
        #1;
        chk(in_ready, "R8 empty slot ready", in_ready, 1);
        @(negedge clk);
        in_act = 16'd600; in_chan = 8'd31; in_waddr = 12'd301;
        for (int k = 0; k < 3; k++) begin
            #1;
            chk(out_valid && out_act == 16'd500, "R8 held beat", out_act, 500);
            chk(!in_ready, "R8 ready low when full", in_ready, 0);
            @(negedge clk);
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        exp_act[exp_n] = 16'd500; exp_chan[exp_n] = 8'd30; exp_addr[exp_n] = 12'd300; exp_n++;
        exp_act[exp_n] = 16'd600; exp_chan[exp_n] = 8'd31; exp_addr[exp_n] = 12'd301; exp_n++;
        exp_total += 2;
        drain();
        check_stream(base, "R8 hold");
    endtask

    task automatic t_random_stall();
        int base = exp_n;
        stall_mode = 1'b1;
        for (int i = 0; i < 60; i++) begin
            logic signed [15:0] a;
            a = 16'(((i * 37) % 21) - 10);
            send(a, 2, 8'(i), 12'(i + 1000));
        end
        drain();
        check_stream(base, "R8 random stall");
        check_counts("R6 after stalls");
    endtask

    task automatic t_clear();
        int base = exp_n;
        @(negedge clk);
        clr = 1'b1; thr_exp = 4'd2; in_act = 16'd100; in_chan = 8'd40; in_waddr = 12'd400;
        in_valid = 1'b1; out_ready = 1'b1;
        @(negedge clk);
        clr = 1'b0; in_valid = 1'b0;
        exp_act[exp_n] = 16'd100; exp_chan[exp_n] = 8'd40; exp_addr[exp_n] = 12'd400; exp_n++;
        exp_total = 0; exp_skip = 0;
        chk(total_cnt == 0 && skip_cnt == 0, "R7 clear wins", total_cnt, 0);
        send(16'sd1, 2, 8'd41, 12'd401);
        drain();
        check_counts("R7 after clear");
        check_stream(base, "R7 data path unaffected");
    endtask

    initial begin
        #(1_000_000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_boundary_n2();
        t_disabled();
        t_max_exp();
        t_layer_change();
        t_hold();
        t_random_stall();
        t_clear();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule